// File: doc/BRIEF.md
# Serial Command Transceiver

This block exchanges one 32-bit word in each direction with an external controller over three push-pull wires. The wires are a serial clock output, a serial data output and a serial data input. A single-cycle request starts the exchange. The command word goes out most significant bit first. In the same pass the block shifts in the controller's reply, one bit per clock period.

The exchange is framed by a start condition and a stop condition. For the start condition, the data output falls while the serial clock is high. For the stop condition, the data output rises while the serial clock is high. Between any two line changes the block waits a programmable number of system clocks. That count is captured when the request is taken.

When the exchange finishes, the block raises a one-cycle done pulse. It presents the reply word with its top two bits replaced by the top two bits of the command, so that a reply always carries the page it answers.

Top module: `cmd_shift_xcvr`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after its release, `sck_o` = 1, `sdo_o` = 1, `busy_o` = 0, `done_o` = 0 and `status_o` = 0.
- R2: A high `start_i` seen at a rising clock edge while `busy_o` is 0 starts an exchange, and `busy_o` is 1 from the next cycle. A high `start_i` while `busy_o` is 1 has no effect, and neither do changes of `cmd_i` during that time.
- R3: Every step of the exchange lasts W system clocks. W is the `tick_i` value captured with the request, and a value of 0 counts as 1. Changes of `tick_i` during an exchange have no effect. An exchange keeps `busy_o` high for exactly 132·W cycles.
- R4: The opening steps are, in order:
  - `sck_o` = 1 and `sdo_o` = 1;
  - `sck_o` = 1 and `sdo_o` = 0;
  - `sck_o` = 0 and `sdo_o` = 0.
- R5: Bits 31 down to 0 of the command follow the opening, in that order. Each bit takes four steps, with `sdo_o` equal to the bit throughout:
  - `sck_o` = 0;
  - `sck_o` = 1;
  - `sck_o` = 0;
  - `sck_o` = 0 held.
- R6: `sdi_i` is sampled at the end of the third step of each bit, which is W clocks after `sck_o` falls. The sample enters the receive word at bit 0 while earlier samples move one place left.
- R7: After the last bit, one step has `sck_o` = 1 and `sdo_o` = 0. Then `sdo_o` returns to 1, and both lines stay high while idle.
- R8: `done_o` is high for exactly one cycle, which is the first cycle in which `busy_o` is 0. From that cycle on, `status_o` bits 31:30 equal `cmd_i` bits 31:30 as captured with the request, and bits 29:0 equal received bits 29:0. `status_o` holds this value until the next `done_o`.
- R9: A `start_i` given in the cycle in which `done_o` is high is taken, and the new exchange begins at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start an exchange |
| cmd_i | input | 32 | Command word to send |
| tick_i | input | 16 | System clocks per step (0 counts as 1) |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 32 | Received word with page bits from the command |
| sck_o | output | 1 | Serial clock to the controller |
| sdo_o | output | 1 | Serial data to the controller |
| sdi_i | input | 1 | Serial data from the controller |

## Verification
Two events can fall in the same cycle: the completion pulse of one exchange and a fresh request. The bench provokes this by raising `start_i` in exactly the cycle where `done_o` is high. It judges the result in four ways:
- `busy_o` must be high in the next cycle;
- the finished status must stay intact;
- the new exchange must open with the full framing from its first step;
- the new exchange must run for its own tick width.

The bench also drives the data input to the inverse of the reply bit in every step except the sampling step. A sample taken one step early or late therefore corrupts the status.

// File: rtl/cmd_xcvr_pkg.sv
package cmd_xcvr_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PREP,   // lines high, settle
    PH_STA,    // data low, clock high
    PH_STB,    // clock low
    PH_BD,     // present data bit
    PH_BH,     // clock high
    PH_BL,     // clock low
    PH_BS,     // sampled, hold
    PH_STOP    // clock high, data low
  } phase_e;
endpackage

// File: rtl/cmd_xcvr_timer.sv
module cmd_xcvr_timer #(
  parameter int TICK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic              step_o
);
  logic [TICK_W-1:0] w_q, cnt_q, w_eff;

  assign w_eff  = (tick_i == '0) ? TICK_W'(1) : tick_i;
  assign step_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q   <= TICK_W'(1);
      cnt_q <= '0;
    end else if (load_i) begin
      w_q   <= w_eff;
      cnt_q <= w_eff - TICK_W'(1);
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= w_q - TICK_W'(1);
      else             cnt_q <= cnt_q - TICK_W'(1);
    end
  end

  a_r3_cnt_below_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < w_q);
  a_r3_step_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !load_i) |=> (cnt_q == w_q - TICK_W'(1)));
endmodule

// File: rtl/cmd_xcvr_shift.sv
module cmd_xcvr_shift #(
  parameter int WORD_W = 32,
  parameter int PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] cmd_i,
  input  logic              tx_shift_i,
  input  logic              sample_i,
  input  logic              sdi_i,
  input  logic              finish_i,
  output logic              tx_bit_o,
  output logic [WORD_W-1:0] status_o
);
  localparam int RX_KEEP = WORD_W - PAGE_W;

  logic [WORD_W-1:0] tx_q, rx_q, status_q;
  logic [PAGE_W-1:0] page_q;

  assign tx_bit_o = tx_q[WORD_W-1];
  assign status_o = status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '0;
      rx_q     <= '0;
      page_q   <= '0;
      status_q <= '0;
    end else begin
      if (load_i) begin
        tx_q   <= cmd_i;
        page_q <= cmd_i[WORD_W-1 -: PAGE_W];
        rx_q   <= '0;
      end else begin
        if (tx_shift_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        if (sample_i)   rx_q <= {rx_q[WORD_W-2:0], sdi_i};
      end
      if (finish_i) status_q <= {page_q, rx_q[RX_KEEP-1:0]};
    end
  end

  a_r6_rx_enters_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !load_i) |=> (rx_q[0] == $past(sdi_i)));
  a_r8_status_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !finish_i |=> $stable(status_o));
endmodule

// File: rtl/cmd_xcvr_ctrl.sv
module cmd_xcvr_ctrl
  import cmd_xcvr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic step_i,
  input  logic tx_bit_i,
  output logic load_o,
  output logic tx_shift_o,
  output logic sample_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o,
  output logic sck_o,
  output logic sdo_o
);
  localparam int BIT_CW = $clog2(WORD_W);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(WORD_W - 1);

  phase_e phase_q, phase_d;
  logic [BIT_CW-1:0] bit_q;
  logic sck_q, sdo_q, sck_d, sdo_d, done_q;

  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;
  assign sck_o  = sck_q;
  assign sdo_o  = sdo_q;

  always_comb begin
    phase_d    = phase_q;
    sck_d      = sck_q;
    sdo_d      = sdo_q;
    load_o     = 1'b0;
    tx_shift_o = 1'b0;
    sample_o   = 1'b0;
    finish_o   = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (start_i) begin
        load_o  = 1'b1;
        phase_d = PH_PREP;
      end
    end else if (step_i) begin
      case (phase_q)
        PH_PREP: begin phase_d = PH_STA; sdo_d = 1'b0; end
        PH_STA:  begin phase_d = PH_STB; sck_d = 1'b0; end
        PH_STB:  begin phase_d = PH_BD;  sdo_d = tx_bit_i; end
        PH_BD:   begin phase_d = PH_BH;  sck_d = 1'b1; tx_shift_o = 1'b1; end
        PH_BH:   begin phase_d = PH_BL;  sck_d = 1'b0; end
        PH_BL:   begin phase_d = PH_BS;  sample_o = 1'b1; end
        PH_BS: begin
          if (bit_q == LAST_BIT) begin
            phase_d = PH_STOP; sck_d = 1'b1; sdo_d = 1'b0;
          end else begin
            phase_d = PH_BD; sdo_d = tx_bit_i;
          end
        end
        PH_STOP: begin phase_d = PH_IDLE; sdo_d = 1'b1; finish_o = 1'b1; end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      sck_q   <= 1'b1;
      sdo_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sck_q   <= sck_d;
      sdo_q   <= sdo_d;
      done_q  <= finish_o;
      if (load_o) bit_q <= '0;
      else if (step_i && phase_q == PH_BS && bit_q != LAST_BIT) bit_q <= bit_q + BIT_CW'(1);
    end
  end

  a_r8_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r7_idle_lines_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o && sdo_o));
  a_r2_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  a_r5_data_steady_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BH || phase_q == PH_BL) |-> $stable(sdo_o));
endmodule

// File: rtl/cmd_shift_xcvr.sv
module cmd_shift_xcvr #(
  parameter int WORD_W = 32,
  parameter int TICK_W = 16,
  parameter int PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] cmd_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] status_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  logic load, step, tx_bit, tx_shift, sample, finish;

  cmd_xcvr_timer #(.TICK_W(TICK_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .run_i  (busy_o),
    .tick_i (tick_i),
    .step_o (step)
  );

  cmd_xcvr_shift #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .cmd_i      (cmd_i),
    .tx_shift_i (tx_shift),
    .sample_i   (sample),
    .sdi_i      (sdi_i),
    .finish_i   (finish),
    .tx_bit_o   (tx_bit),
    .status_o   (status_o)
  );

  cmd_xcvr_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .step_i     (step),
    .tx_bit_i   (tx_bit),
    .load_o     (load),
    .tx_shift_o (tx_shift),
    .sample_o   (sample),
    .finish_o   (finish),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sck_o      (sck_o),
    .sdo_o      (sdo_o)
  );
endmodule

// File: tb/cmd_shift_xcvr_tb.sv
module cmd_shift_xcvr_tb;
  localparam int STEPS = 132;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] cmd_i = '0;
  logic [15:0] tick_i = 16'd1;
  logic        sdi_i = 1'b1;
  logic        busy_o, done_o, sck_o, sdo_o;
  logic [31:0] status_o;

  always #10 clk = ~clk;

  cmd_shift_xcvr u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i),
    .tick_i(tick_i), .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
    .sck_o(sck_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] reply = '0;

  // behavioural reference
  bit          m_busy, m_done;
  int          m_n, m_w, nn;
  logic [31:0] m_cmd, m_rx, m_status;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 0; m_done <= 0; m_n <= 0; m_w <= 1;
      m_cmd <= '0; m_rx <= '0; m_status <= '0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (start_i) begin
          m_busy <= 1; m_n <= 0; m_cmd <= cmd_i; m_rx <= '0;
          m_w <= (tick_i == 0) ? 1 : int'(tick_i);
        end
      end else begin
        nn = m_n + 1;
        if (nn == STEPS * m_w) begin
          m_busy <= 0; m_done <= 1;
          m_status <= {m_cmd[31:30], m_rx[29:0]};
        end else begin
          m_n <= nn;
          if (nn % m_w == 0 && nn / m_w >= 3 && ((nn / m_w - 3) % 4) == 3)
            m_rx <= {m_rx[30:0], sdi_i};
        end
      end
    end
  end

  // compare every cycle, then drive the controller's data line
  always @(negedge clk) begin
    int p, b, s;
    logic ek, ed;
    string tag;
    if (rst_ni && !finished) begin
      chk("R2", "busy", 32'(busy_o), 32'(m_busy));
      chk("R8", "done", 32'(done_o), 32'(m_done));
      chk("R8", "status", status_o, m_status);
      ek = 1'b1; ed = 1'b1; tag = "R7";
      if (m_busy) begin
        p = m_n / m_w;
        if (p == 0)        begin ek = 1; ed = 1; tag = "R4"; end
        else if (p == 1)   begin ek = 1; ed = 0; tag = "R4"; end
        else if (p == 2)   begin ek = 0; ed = 0; tag = "R4"; end
        else if (p == 131) begin ek = 1; ed = 0; tag = "R7"; end
        else begin
          b = (p - 3) / 4; s = (p - 3) % 4;
          ed = m_cmd[31-b]; ek = (s == 1); tag = "R5";
        end
      end
      chk(tag, "sck", 32'(sck_o), 32'(ek));
      chk(tag, "sdo", 32'(sdo_o), 32'(ed));
    end
    if (m_busy && (m_n / m_w) >= 3 && (m_n / m_w) <= 130) begin
      p = m_n / m_w; b = (p - 3) / 4; s = (p - 3) % 4;
      sdi_i = (s == 2) ? reply[31-b] : ~reply[31-b];
    end else sdi_i = 1'b1;
  end

  // called at a negedge
  task automatic launch(input logic [31:0] c, input logic [31:0] r, input logic [15:0] t, input string req);
    cmd_i = c; tick_i = t; reply = r; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(req, "busy after start", 32'(busy_o), 32'd1);
  endtask

  // returns at the negedge where done_o is high
  task automatic await_done(input logic [31:0] c, input logic [31:0] r, input int w);
    int cnt = 1;
    int i = 0;
    while (!done_o) begin
      @(negedge clk);
      i++;
      if (i == 10) begin cmd_i = ~c; tick_i = 16'd7; start_i = 1'b1; end  // R2 R3: ignored while busy
      if (i == 11) start_i = 1'b0;
      if (busy_o) cnt++;
    end
    chk("R3", "busy cycles", 32'(cnt), 32'(STEPS * w));
    chk("R6", "status word", status_o, {c[31:30], r[29:0]});
    chk("R8", "busy low at done", 32'(busy_o), 32'd0);
  endtask

  task automatic summary();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "sck in reset", 32'(sck_o), 32'd1);
    chk("R1", "sdo in reset", 32'(sdo_o), 32'd1);
    chk("R1", "busy in reset", 32'(busy_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", 32'(done_o), 32'd0);
    chk("R1", "status after reset", status_o, 32'd0);
    chk("R1", "lines after reset", {30'd0, sck_o, sdo_o}, 32'd3);

    launch(32'hA5C3_0F1E, 32'h3CF0_5A96, 16'd1, "R2");
    await_done(32'hA5C3_0F1E, 32'h3CF0_5A96, 1);
    repeat (2) @(negedge clk);
    launch(32'h4000_0001, 32'hFFFF_FFFF, 16'd2, "R2");
    await_done(32'h4000_0001, 32'hFFFF_FFFF, 2);
    repeat (3) @(negedge clk);
    launch(32'hC000_0000, 32'h0000_0000, 16'd0, "R3");   // tick 0 counts as 1
    await_done(32'hC000_0000, 32'h0000_0000, 1);
    @(negedge clk);
    launch(32'h1234_5678, 32'h8765_4321, 16'd3, "R2");
    await_done(32'h1234_5678, 32'h8765_4321, 3);
    launch(32'h8000_00FF, 32'h5555_AAAA, 16'd1, "R9");   // start in the done cycle
    chk("R9", "first status kept", status_o, 32'h0765_4321);
    await_done(32'h8000_00FF, 32'h5555_AAAA, 1);
    repeat (4) @(negedge clk);
    chk("R7", "idle lines", {30'd0, sck_o, sdo_o}, 32'd3);
    chk("R8", "status held", status_o, 32'h9555_AAAA);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule